// File: doc/BRIEF.md
# Display Power-Up Init Sequencer

This block brings a small display controller out of reset. It sits above a register-frame master that moves one serial frame per request. After a start pulse, the sequencer first reads the controller's identification register and decides whether a supported chip is present. If one is found, it plays a fixed programme of register writes with millisecond pauses between some of them. The programme starts the oscillator, selects the pixel-stream interface, runs the power-up steps, and loads the gamma, scroll and window settings. It ends by parking the index register on the frame-memory write port.

When initialisation is over, the recorded power state is off, and the sequencer immediately runs a power-on pass. From then on it follows a level-sensitive power request. It runs the power-on or power-off programme only when the request differs from the recorded state. The recorded state changes only once a programme has finished. Power-off and power-on share the same discharge steps, and power-on then adds its charge-up steps.

Each pause is a down-counter loaded with the pause length in milliseconds times `CLK_PER_MS`. The register programme is held in an internal step table.

Top module: `panel_bringup_seq`

## Requirements
- R1: After reset, `mst_req`, `ready`, `no_chip` and `powered` are all low, and nothing happens until `start` is pulsed.
- R2: Each frame is one request. `mst_req` stays high, with `mst_kind` and `mst_data` stable, until `mst_done`. It drops on the following cycle, and at least one cycle without a request separates two frames. `mst_kind` encodes 0 as an index write, 1 as a data write and 2 as a data read.
- R3: A register write is an index frame followed by a data frame. The index frame carries the register number in `mst_data[7:0]` with `mst_data[15:8]` zero. The data frame carries the 16-bit value.
- R4: The first frames after `start` are an index frame for register 0x00 and then a read frame whose `mst_data` is zero. The chip counts as present only when `mst_rdata & 0xFFF0 == 0x9220`. Otherwise `no_chip` rises and stays high, no further frame is issued, and `ready` never rises.
- R5: After the identification read, the init programme writes 0x0001 to register 0x00 and pauses 10 ms. It then writes 0x01=0x691B, 0x02=0x0700, 0x03=0x1030, 0x07=0x0037, 0x08=0x0202 and 0x0C=0x0110, and runs the power-on programme. After that it writes 0x30..0x39 = 0x0302, 0x0407, 0x0304, 0x0203, 0x0706, 0x0407, 0x0706, 0x0000, 0x0C06, 0x0F00. Last it writes 0x21=0, 0x40=0, 0x41=0, 0x42=0xDB00, 0x43=0xDB00, 0x44=0xAF00 and 0x45=0xDB00.
- R6: Before the request that follows a pause of M ms, the previous frame's `mst_done` is followed by at least M*`CLK_PER_MS` cycles without a request, and by no more than a few cycles beyond that.
- R7: The init programme closes with a lone index frame for register 0x22, with no data frame, and is then followed at once by the power-on programme.
- R8: When that first power-on pass ends, `powered` and `ready` rise together.
- R9: The power-off programme writes 0x0000 to register 0x10, pauses 10 ms, writes 0x0000 to 0x11 and to 0x12, pauses 40 ms, writes 0x0000 to 0x13 and pauses 40 ms. It runs when `power_req` falls to 0 while `powered` is 1. `powered` stays 1 until the programme ends.
- R10: The power-on programme is the power-off programme followed by 0x56=0x080F, 0x10=0x4240, a 10 ms pause, 0x11=0x0000, 0x12=0x0014, a 40 ms pause, 0x13=0x1319 and a 40 ms pause. It runs when `power_req` is 1 while `powered` is 0.
- R11: In the idle state, a `power_req` equal to `powered`, or a `start` pulse, issues no frame and leaves `ready` high.
- R12: Changes of `power_req` while initialisation runs have no effect on the frames issued.
- R13: `ready` is high only in the idle state after initialisation, and never while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins identification and initialisation |
| power_req | input | 1 | Requested power state, 1 = on |
| mst_req | output | 1 | Frame request toward the register master |
| mst_kind | output | 2 | Frame kind: 0 index write, 1 data write, 2 data read |
| mst_data | output | 16 | Index number or data value for the frame |
| mst_done | input | 1 | One-cycle completion pulse from the register master |
| mst_rdata | input | 16 | Data returned by a read frame, valid with `mst_done` |
| ready | output | 1 | Idle after initialisation, accepting power requests |
| no_chip | output | 1 | Identification failed, sequencer halted |
| powered | output | 1 | Recorded power state |

## Verification
The checks assume a register master that raises `mst_done` for exactly one cycle, and only while `mst_req` is high. They also assume `mst_rdata` is valid in that cycle. The bench's master model answers each request after a random delay of zero to three cycles and never pulses `mst_done` unrequested. It returns a fixed identification word chosen per scenario. `power_req` is toggled at random only during initialisation, where it must be ignored, and is then driven to directed levels.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   typedef enum logic [2:0] {
      OP_WRITE,
      OP_WAIT,
      OP_READID,
      OP_INDEX,
      OP_CALL,
      OP_OFFEND,
      OP_RET,
      OP_INITEND
   } op_e;

   typedef enum logic [1:0] {
      FR_INDEX = 2'd0,
      FR_WRITE = 2'd1,
      FR_READ  = 2'd2
   } frame_e;

   typedef struct packed {
      op_e         op;
      logic [7:0]  addr;
      logic [15:0] val;
      logic [5:0]  ms;
   } step_t;

   localparam int STEPS    = 46;
   localparam int PWR_BASE = 29;
   localparam int LONGEST_MS = 40;
   localparam logic [15:0] ID_MASK  = 16'hFFF0;
   localparam logic [15:0] ID_MATCH = 16'h9220;

   function automatic step_t wr(logic [7:0] a, logic [15:0] v);
      return '{op: OP_WRITE, addr: a, val: v, ms: 6'd0};
   endfunction

   function automatic step_t pause(logic [5:0] m);
      return '{op: OP_WAIT, addr: 8'h00, val: 16'h0000, ms: m};
   endfunction

   function automatic step_t ctl(op_e o, logic [7:0] a);
      return '{op: o, addr: a, val: 16'h0000, ms: 6'd0};
   endfunction

   // Step table: init programme at 0, shared power programme at PWR_BASE.
   function automatic step_t step_at(int unsigned i);
      case (i)
         0:  return ctl(OP_READID, 8'h00);
         1:  return wr(8'h00, 16'h0001);
         2:  return pause(6'd10);
         3:  return wr(8'h01, 16'h691B);
         4:  return wr(8'h02, 16'h0700);
         5:  return wr(8'h03, 16'h1030);
         6:  return wr(8'h07, 16'h0037);
         7:  return wr(8'h08, 16'h0202);
         8:  return wr(8'h0C, 16'h0110);
         9:  return ctl(OP_CALL, 8'h00);
         10: return wr(8'h30, 16'h0302);
         11: return wr(8'h31, 16'h0407);
         12: return wr(8'h32, 16'h0304);
         13: return wr(8'h33, 16'h0203);
         14: return wr(8'h34, 16'h0706);
         15: return wr(8'h35, 16'h0407);
         16: return wr(8'h36, 16'h0706);
         17: return wr(8'h37, 16'h0000);
         18: return wr(8'h38, 16'h0C06);
         19: return wr(8'h39, 16'h0F00);
         20: return wr(8'h21, 16'h0000);
         21: return wr(8'h40, 16'h0000);
         22: return wr(8'h41, 16'h0000);
         23: return wr(8'h42, 16'hDB00);
         24: return wr(8'h43, 16'hDB00);
         25: return wr(8'h44, 16'hAF00);
         26: return wr(8'h45, 16'hDB00);
         27: return ctl(OP_INDEX, 8'h22);
         28: return ctl(OP_INITEND, 8'h00);
         29: return wr(8'h10, 16'h0000);
         30: return pause(6'd10);
         31: return wr(8'h11, 16'h0000);
         32: return wr(8'h12, 16'h0000);
         33: return pause(6'd40);
         34: return wr(8'h13, 16'h0000);
         35: return pause(6'd40);
         36: return ctl(OP_OFFEND, 8'h00);
         37: return wr(8'h56, 16'h080F);
         38: return wr(8'h10, 16'h4240);
         39: return pause(6'd10);
         40: return wr(8'h11, 16'h0000);
         41: return wr(8'h12, 16'h0014);
         42: return pause(6'd40);
         43: return wr(8'h13, 16'h1319);
         44: return pause(6'd40);
         default: return ctl(OP_RET, 8'h00);
      endcase
   endfunction

endpackage

// File: rtl/panel_step_rom.sv
module panel_step_rom
   import panel_seq_pkg::*;
#(
   parameter int PC_W = 6
) (
   input  logic [PC_W-1:0] pc,
   output step_t           step
);

   generate
      if ((1 << PC_W) < STEPS) begin : g_bad_width
         $error("panel_step_rom: PC_W too narrow for the step table");
      end
   endgenerate

   always_comb step = step_at(32'(pc));

endmodule

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
   parameter int CLK_PER_MS = 125000,
   parameter int MAX_MS     = 40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [5:0] ms,
   output logic       expired
);

   localparam longint LIMIT = longint'(CLK_PER_MS) * longint'(MAX_MS);
   localparam int     CW    = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= CW'(longint'(ms) * longint'(CLK_PER_MS));
      else if (cnt != '0)
         cnt <= cnt - CW'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq #(
   parameter int CLK_PER_MS = 125000,
   parameter int MAX_MS     = 40
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        power_req,
   output logic        mst_req,
   output logic [1:0]  mst_kind,
   output logic [15:0] mst_data,
   input  logic        mst_done,
   input  logic [15:0] mst_rdata,
   output logic        ready,
   output logic        no_chip,
   output logic        powered
);
   import panel_seq_pkg::*;

   localparam int PC_W = $clog2(STEPS);

   generate
      if (CLK_PER_MS < 1) begin : g_bad_clk
         $error("panel_bringup_seq: CLK_PER_MS must be at least 1");
      end
      if (MAX_MS < LONGEST_MS || MAX_MS > 63) begin : g_bad_ms
         $error("panel_bringup_seq: MAX_MS must lie in 40..63");
      end
   endgenerate

   typedef enum logic [2:0] {
      ST_HALT, ST_STEP, ST_IDX, ST_DAT, ST_DELAY, ST_NOCHIP, ST_IDLE
   } state_e;

   state_e          state;
   logic [PC_W-1:0] pc, ret_pc;
   logic            in_init, dir_on;
   step_t           step;
   logic            t_load, t_expired;

   panel_step_rom #(.PC_W(PC_W)) i_rom (
      .pc   (pc),
      .step (step)
   );

   assign t_load = (state == ST_STEP) && (step.op == OP_WAIT);

   panel_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MAX_MS(MAX_MS)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .ms      (step.ms),
      .expired (t_expired)
   );

   always_comb begin
      if (state == ST_IDX) begin
         mst_kind = FR_INDEX;
         mst_data = {8'h00, step.addr};
      end else begin
         mst_kind = (step.op == OP_READID) ? FR_READ : FR_WRITE;
         mst_data = step.val;
      end
   end

   assign ready   = (state == ST_IDLE);
   assign no_chip = (state == ST_NOCHIP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_HALT;
         pc      <= '0;
         ret_pc  <= '0;
         in_init <= 1'b0;
         dir_on  <= 1'b0;
         powered <= 1'b0;
         mst_req <= 1'b0;
      end else begin
         case (state)
            ST_HALT: if (start) begin
               pc      <= '0;
               in_init <= 1'b1;
               dir_on  <= 1'b1;
               state   <= ST_STEP;
            end
            ST_STEP: begin
               case (step.op)
                  OP_WRITE, OP_READID, OP_INDEX: state <= ST_IDX;
                  OP_WAIT: state <= ST_DELAY;
                  OP_CALL: begin
                     ret_pc <= pc + PC_W'(1);
                     pc     <= PC_W'(PWR_BASE);
                  end
                  OP_OFFEND: begin
                     if (dir_on) pc <= pc + PC_W'(1);
                     else begin
                        powered <= 1'b0;
                        state   <= ST_IDLE;
                     end
                  end
                  OP_RET: begin
                     if (in_init) pc <= ret_pc;
                     else begin
                        powered <= 1'b1;
                        state   <= ST_IDLE;
                     end
                  end
                  OP_INITEND: begin
                     in_init <= 1'b0;
                     powered <= 1'b0;
                     dir_on  <= 1'b1;
                     pc      <= PC_W'(PWR_BASE);
                  end
                  default: state <= ST_IDLE;
               endcase
            end
            ST_IDX: begin
               if (!mst_req) mst_req <= 1'b1;
               else if (mst_done) begin
                  mst_req <= 1'b0;
                  if (step.op == OP_INDEX) begin
                     pc    <= pc + PC_W'(1);
                     state <= ST_STEP;
                  end else begin
                     state <= ST_DAT;
                  end
               end
            end
            ST_DAT: begin
               if (!mst_req) mst_req <= 1'b1;
               else if (mst_done) begin
                  mst_req <= 1'b0;
                  if (step.op == OP_READID && ((mst_rdata & ID_MASK) != ID_MATCH))
                     state <= ST_NOCHIP;
                  else begin
                     pc    <= pc + PC_W'(1);
                     state <= ST_STEP;
                  end
               end
            end
            ST_DELAY: if (t_expired) begin
               pc    <= pc + PC_W'(1);
               state <= ST_STEP;
            end
            ST_NOCHIP: state <= ST_NOCHIP;
            ST_IDLE: if (power_req != powered) begin
               dir_on <= power_req;
               pc     <= PC_W'(PWR_BASE);
               state  <= ST_STEP;
            end
            default: state <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        power_req,
   input logic        mst_req,
   input logic [1:0]  mst_kind,
   input logic [15:0] mst_data,
   input logic        mst_done,
   input logic [15:0] mst_rdata,
   input logic        ready,
   input logic        no_chip,
   input logic        powered
);

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mst_req && !mst_done |=> mst_req && $stable(mst_kind) && $stable(mst_data));

   a_r2_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
      mst_req && mst_done |=> !mst_req);

   a_r3_index_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mst_req && mst_kind == 2'd0 |-> mst_data[15:8] == 8'h00);

   a_r4_nochip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      no_chip |-> !mst_req && !ready);

   a_r4_nochip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      no_chip |=> no_chip);

   a_r9_power_flip_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(powered) |-> ready);

   a_r11_unchanged_stays: assert property (@(posedge clk) disable iff (!rst_n)
      ready && (power_req == powered) |=> ready);

   a_r13_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !mst_req);

endmodule

bind panel_bringup_seq panel_seq_chk i_chk (.*);

// File: tb/test_panel_bringup_seq.sv
module test_panel_bringup_seq;

   localparam int CPM = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        power_req = 1'b0;
   logic        mst_req;
   logic [1:0]  mst_kind;
   logic [15:0] mst_data;
   logic        mst_done = 1'b0;
   logic [15:0] mst_rdata = 16'h0000;
   logic        ready, no_chip, powered;

   always #4 clk = ~clk;

   panel_bringup_seq #(.CLK_PER_MS(CPM), .MAX_MS(40)) i_panel_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .power_req(power_req),
      .mst_req(mst_req), .mst_kind(mst_kind), .mst_data(mst_data),
      .mst_done(mst_done), .mst_rdata(mst_rdata),
      .ready(ready), .no_chip(no_chip), .powered(powered));

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;

   logic [1:0]  fk [256];
   logic [15:0] fd [256];
   int          fs [256], fe [256];
   int          nf = 0;

   logic [1:0]  ek [256];
   logic [15:0] ed [256];
   int          eg [256];
   int          ne = 0, pend = 0;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // register-master model
   initial begin
      bit busy = 0;
      int dly = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst_n) begin busy = 0; mst_done = 1'b0; end
         else if (mst_done) mst_done = 1'b0;
         else if (mst_req) begin
            if (!busy) begin
               busy = 1;
               dly = $urandom % 4;
               if (nf < 256) fs[nf] = cyc;
            end
            if (dly > 0) dly--;
            else begin
               if (nf < 256) begin
                  fk[nf] = mst_kind; fd[nf] = mst_data; fe[nf] = cyc;
               end
               nf++;
               mst_done = 1'b1;
               busy = 0;
            end
         end
      end
   end

   task automatic e_frame(logic [1:0] k, logic [15:0] d);
      ek[ne] = k; ed[ne] = d; eg[ne] = pend; pend = 0; ne++;
   endtask
   task automatic e_wr(logic [7:0] a, logic [15:0] v);
      e_frame(2'd0, {8'h00, a});
      e_frame(2'd1, v);
   endtask
   task automatic e_off();
      e_wr(8'h10, 16'h0000); pend = 10;
      e_wr(8'h11, 16'h0000); e_wr(8'h12, 16'h0000); pend = 40;
      e_wr(8'h13, 16'h0000); pend = 40;
   endtask
   task automatic e_on();
      e_off();
      e_wr(8'h56, 16'h080F); e_wr(8'h10, 16'h4240); pend = 10;
      e_wr(8'h11, 16'h0000); e_wr(8'h12, 16'h0014); pend = 40;
      e_wr(8'h13, 16'h1319); pend = 40;
   endtask

   task automatic compare(string req);
      chk(nf == ne, {req, " frame count"}, nf, ne);
      for (int i = 0; i < ne && i < nf; i++) begin
         chk(fk[i] == ek[i] && fd[i] == ed[i], {req, " frame"},
             {fk[i], fd[i]}, {ek[i], ed[i]});
         if (i > 0) begin
            int gap = fs[i] - fe[i-1];
            chk(gap >= 1, "R2 idle cycle between frames", gap, 1);
            if (eg[i] > 0)
               chk(gap >= eg[i] * CPM && gap <= eg[i] * CPM + 8,
                   "R6 pause length", gap, eg[i] * CPM);
         end
      end
   endtask

   task automatic wait_ready(int limit);
      for (int i = 0; i < limit && !ready; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      nf = 0; ne = 0; pend = 0;
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(!mst_req && !ready && !no_chip && !powered, "R1 reset outputs",
          {mst_req, ready, no_chip, powered}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(nf == 0 && !ready, "R1 idle before start", nf, 0);

      // R4 wrong identification word
      mst_rdata = 16'h9320;
      nf = 0;
      pulse_start();
      repeat (200) @(negedge clk);
      chk(no_chip == 1'b1, "R4 no_chip on mismatch", no_chip, 1);
      chk(nf == 2, "R4 no frame after failed id", nf, 2);
      chk(fk[0] == 2'd0 && fd[0] == 16'h0000, "R4 id index frame", {fk[0], fd[0]}, 0);
      chk(fk[1] == 2'd2 && fd[1] == 16'h0000, "R4 id read frame", {fk[1], fd[1]}, 32'h20000);
      chk(!ready, "R4 ready stays low", ready, 0);

      // full init with masked id match, power_req noise during init (R12)
      do_reset();
      mst_rdata = 16'h922B;
      e_frame(2'd0, 16'h0000); e_frame(2'd2, 16'h0000);
      e_wr(8'h00, 16'h0001); pend = 10;
      e_wr(8'h01, 16'h691B); e_wr(8'h02, 16'h0700); e_wr(8'h03, 16'h1030);
      e_wr(8'h07, 16'h0037); e_wr(8'h08, 16'h0202); e_wr(8'h0C, 16'h0110);
      e_on();
      e_wr(8'h30, 16'h0302); e_wr(8'h31, 16'h0407); e_wr(8'h32, 16'h0304);
      e_wr(8'h33, 16'h0203); e_wr(8'h34, 16'h0706); e_wr(8'h35, 16'h0407);
      e_wr(8'h36, 16'h0706); e_wr(8'h37, 16'h0000); e_wr(8'h38, 16'h0C06);
      e_wr(8'h39, 16'h0F00);
      e_wr(8'h21, 16'h0000); e_wr(8'h40, 16'h0000); e_wr(8'h41, 16'h0000);
      e_wr(8'h42, 16'hDB00); e_wr(8'h43, 16'hDB00); e_wr(8'h44, 16'hAF00);
      e_wr(8'h45, 16'hDB00);
      e_frame(2'd0, 16'h0022);   // R7 lone index frame
      e_on();                    // R7 power-on follows at once
      pulse_start();
      for (int i = 0; i < 1500; i++) begin
         if (i % 37 == 0) power_req = $urandom % 2;
         @(negedge clk);
      end
      power_req = 1'b1;
      wait_ready(20000);
      compare("R5 R7 R10 R12 init programme");
      chk(ready && powered, "R8 powered and ready after init", {ready, powered}, 2'b11);

      // R11 unchanged request and start in idle
      nf = 0;
      pulse_start();
      repeat (300) @(negedge clk);
      chk(nf == 0 && ready, "R11 no frames when unchanged", nf, 0);
      chk(!no_chip, "R13 no_chip low when ready", no_chip, 0);

      // R9 power off
      nf = 0; ne = 0; pend = 0;
      e_off();
      power_req = 1'b0;
      for (int i = 0; i < 2000 && nf < 3; i++) @(negedge clk);
      chk(powered == 1'b1 && !ready, "R9 powered held mid-sequence", powered, 1);
      wait_ready(20000);
      compare("R9 power-off programme");
      chk(!powered && ready, "R9 powered low after off", powered, 0);

      nf = 0;
      repeat (250) @(negedge clk);
      chk(nf == 0, "R11 off held, no frames", nf, 0);

      // R10 power on
      nf = 0; ne = 0; pend = 0;
      e_on();
      power_req = 1'b1;
      @(negedge clk);
      chk(!ready, "R13 ready low while sequence runs", ready, 0);
      wait_ready(20000);
      compare("R10 power-on programme");
      chk(powered && ready, "R10 powered after on", powered, 1);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule